// File: doc/BRIEF.md
# Configurable SPI Serial Port

A single serial peripheral port that acts either as the bus master or as a slave. In both roles it moves 8-bit frames in clock mode 0: SCK idles low, data is presented while SCK is low and captured on each rising SCK edge. As master it derives SCK from the system clock through a power-of-two prescaler and generates the frame itself. As slave it follows an external SCK while its effective chip select is low. Received frames land in a receive register with a ready flag. A busy flag covers the frame in progress.

The control word is applied as a set of static inputs: enable, master/slave role, a 3-bit rate code, bit order, a software-select override with its own select level, and a receive-only switch that releases the data output. Rate, order and role are captured when the port is idle and held until the frame ends. Changing them mid-frame therefore has no effect on the frame in flight.

The port has a single serial data input and a single serial data output with an output enable. The surrounding pad logic routes these to MOSI/MISO according to the role. All slave-side inputs are brought into the system clock domain through a two-stage synchronizer.

Top module: `spi_port`

## Requirements
- R1: As master, SCK has a period of 2^(code+1) system clocks for rate code `cfg_baud` 0..7 (000 gives /2, 111 gives /256). `sck_out` is 0 whenever no master frame is running.
- R2: As master, a `tx_write` pulse while enabled and idle starts a frame. `busy` is 1 from the next cycle until the falling SCK edge after the eighth rising edge. Exactly 8 rising edges occur. At the end, `rx_data` holds the 8 bits taken from `ser_in` on the rising edges and `rx_ready` is 1.
- R3: With `cfg_lsb_first`=0 bit 7 goes out and comes in first. With `cfg_lsb_first`=1 bit 0 goes out and comes in first. This holds in both roles and both directions.
- R4: Changing `cfg_baud`, `cfg_lsb_first` or `cfg_master` during a frame does not alter that frame's period, bit order or role.
- R5: As slave with effective select low, the port captures `ser_in` on rising `sck_in` edges and presents the last written transmit byte on `ser_out`, changing it on falling edges. After 8 rising edges it loads `rx_data` and sets `rx_ready`.
- R6: With `cfg_sw_sel`=1, `cfg_sw_sel_val` replaces `sel_n_in` as the active-low select and the pin is ignored. With `cfg_sw_sel`=0, `cfg_sw_sel_val` has no effect.
- R7: Deselecting a slave mid-frame clears its bit count. No `rx_ready` results, `busy` drops, and the next selected frame is received whole.
- R8: With `cfg_rx_only`=1, `ser_out_en` stays 0 and `ser_out` stays 0, while reception works unchanged.
- R9: With `cfg_en`=0 the port is idle: a running frame is abandoned, `busy` and `sck_out` are 0 one cycle later, no `rx_ready` is produced, and `tx_write` starts nothing.
- R10: `rx_read` clears `rx_ready`. A `tx_write` during a master frame is ignored.
- R11: `ser_out_en` is 1 for an enabled master, and for an enabled slave only while selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | Port enable |
| cfg_master | input | 1 | 1 = master, 0 = slave |
| cfg_baud | input | 3 | Rate code, SCK = clk / 2^(code+1) |
| cfg_lsb_first | input | 1 | 1 = bit 0 first, 0 = bit 7 first |
| cfg_sw_sel | input | 1 | 1 = use software select level |
| cfg_sw_sel_val | input | 1 | Software select level (active low) |
| cfg_rx_only | input | 1 | 1 = release data output |
| tx_data | input | 8 | Transmit byte |
| tx_write | input | 1 | Write strobe for tx_data |
| rx_read | input | 1 | Clears rx_ready |
| rx_data | output | 8 | Last received byte |
| rx_ready | output | 1 | Received byte waiting |
| busy | output | 1 | Frame in progress |
| sck_out | output | 1 | Master serial clock |
| sck_in | input | 1 | Slave serial clock |
| sel_n_in | input | 1 | Slave select pin, active low |
| ser_out | output | 1 | Serial data out |
| ser_out_en | output | 1 | Output enable for ser_out |
| ser_in | input | 1 | Serial data in |

## Verification
As master, `busy` is due one cycle after the `tx_write` edge and `rx_ready`/`rx_data` at the same edge that drops `busy`. The bench therefore polls `busy` at falling clock edges and checks the results at the first sample where it is low. SCK period is measured as the count of falling-clock samples between successive rising SCK samples. As slave, inputs pass a two-flop synchronizer plus an edge register, so the bench holds each SCK phase 8 clocks and samples `ser_out` at the end of the low phase, by when the shift is settled. Disable effects are checked one sample after `cfg_en` falls.

// File: rtl/spi_port_pkg.sv
// Shared types for the SPI port: frame settings captured while idle.
package spi_port_pkg;
    localparam int BAUD_W = 3;

    // Settings frozen for the duration of a frame.
    typedef struct packed {
        logic              master;
        logic              lsb_first;
        logic [BAUD_W-1:0] baud;
    } frame_cfg_t;
endpackage

// File: rtl/spi_baud_gen.sv
// Half-period tick generator. Emits a one-cycle tick every 2^code clocks
// while run is high; the counter restarts whenever run is low.
// Assumes code is held stable while run is high.
module spi_baud_gen #(
    parameter int BAUD_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [BAUD_W-1:0] code,
    output logic              tick
);
    localparam int MAX_LOG = (1 << BAUD_W) - 1;
    localparam int CNT_W   = MAX_LOG + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    assign limit = (CNT_W'(1) << code) - CNT_W'(1);
    assign tick  = run && (cnt == limit);

    // Count clocks within the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || tick)
            cnt <= '0;
        else
            cnt <= cnt + CNT_W'(1);
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= limit)) else $error("half-period counter overran"); // R1
endmodule

// File: rtl/spi_in_sync.sv
// Multi-stage synchronizer for a group of asynchronous inputs.
// Assumes each bit is sampled independently; skew between bits is
// tolerated because the consumer waits several clocks per phase.
module spi_in_sync #(
    parameter int         W       = 3,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    // First stage captures the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) stage[0] <= RST_VAL;
        else        stage[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Each further stage re-registers the previous one.
        always_ff @(posedge clk) begin
            if (!rst_n) stage[s] <= RST_VAL;
            else        stage[s] <= stage[s-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/spi_frame_engine.sv
// Shift datapath shared by both roles: a transmit shifter, a receive
// shifter and a bit counter. The caller supplies sample and shift strobes
// (never both in one cycle), a load strobe and a counter clear.
module spi_frame_engine #(
    parameter int FRAME_W = 8,
    localparam int CW     = $clog2(FRAME_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lsb_first,
    input  logic               clear,
    input  logic               load,
    input  logic [FRAME_W-1:0] load_data,
    input  logic               sample,
    input  logic               shift,
    input  logic               in_bit,
    output logic               out_bit,
    output logic [FRAME_W-1:0] rx_word,
    output logic [CW-1:0]      bit_count
);
    logic [FRAME_W-1:0] tx_sh;
    logic [FRAME_W-1:0] rx_sh;

    assign out_bit = lsb_first ? tx_sh[0] : tx_sh[FRAME_W-1];
    assign rx_word = rx_sh;

    // Transmit shifter: load wins over shift.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tx_sh <= '0;
        else if (load)
            tx_sh <= load_data;
        else if (shift)
            tx_sh <= lsb_first ? (tx_sh >> 1) : (tx_sh << 1);
    end

    // Receive shifter: new bit enters at the end opposite to the first bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rx_sh <= '0;
        else if (sample)
            rx_sh <= lsb_first ? {in_bit, rx_sh[FRAME_W-1:1]}
                               : {rx_sh[FRAME_W-2:0], in_bit};
    end

    // Bit counter: counts sampled bits, cleared by the caller.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bit_count <= '0;
        else if (clear)
            bit_count <= '0;
        else if (sample)
            bit_count <= bit_count + CW'(1);
    end

    AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        bit_count <= CW'(FRAME_W)) else $error("bit count past frame"); // R2
    AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample && shift)) else $error("sample and shift together"); // R2
endmodule

// File: rtl/spi_port.sv
// SPI port, master or slave, clock mode 0, fixed-size frames.
// Master: divides clk for SCK, starts a frame on tx_write when idle.
// Slave: follows synchronized sck_in while the effective select is low.
// Assumes slave SCK phases last at least four clk cycles.
module spi_port
    import spi_port_pkg::*;
#(
    parameter int FRAME_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_en,
    input  logic               cfg_master,
    input  logic [BAUD_W-1:0]  cfg_baud,
    input  logic               cfg_lsb_first,
    input  logic               cfg_sw_sel,
    input  logic               cfg_sw_sel_val,
    input  logic               cfg_rx_only,
    input  logic [FRAME_W-1:0] tx_data,
    input  logic               tx_write,
    input  logic               rx_read,
    output logic [FRAME_W-1:0] rx_data,
    output logic               rx_ready,
    output logic               busy,
    output logic               sck_out,
    input  logic               sck_in,
    input  logic               sel_n_in,
    output logic               ser_out,
    output logic               ser_out_en,
    input  logic               ser_in
);
    localparam int CW = $clog2(FRAME_W + 1);

    frame_cfg_t         fcfg;
    logic [FRAME_W-1:0] tx_buf;
    logic [FRAME_W-1:0] rx_word;
    logic [CW-1:0]      bit_count;
    logic [2:0]         sync_q;
    logic               sck_s, sel_s, din_s, sck_prev;
    logic               m_run, sck_r, tick;
    logic               m_start, m_sample, m_fall, m_done, m_shift;
    logic               s_active, s_sample, s_shift, s_done;
    logic               sel_eff_n, frame_full, out_bit;
    logic               eng_clear, eng_load, eng_sample, eng_shift, eng_in;

    // Slave-side pins into the clk domain; select resets inactive.
    spi_in_sync #(.W(3), .STAGES(2), .RST_VAL(3'b010)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({ser_in, sel_n_in, sck_in}), .q(sync_q)
    );
    assign sck_s = sync_q[0];
    assign sel_s = sync_q[1];
    assign din_s = sync_q[2];

    // Previous synchronized SCK for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_prev <= 1'b0;
        else        sck_prev <= sck_s;
    end

    assign busy       = m_run || (bit_count != '0);
    assign frame_full = (bit_count == CW'(FRAME_W));

    // Capture frame settings only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fcfg <= '0;
        else if (!busy)
            fcfg <= '{master: cfg_master, lsb_first: cfg_lsb_first, baud: cfg_baud};
    end

    // ---------------- master side ----------------
    assign m_start = cfg_en && cfg_master && tx_write && !busy;

    spi_baud_gen #(.BAUD_W(BAUD_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .run(m_run), .code(fcfg.baud), .tick(tick)
    );

    assign m_sample = m_run && tick && !sck_r;
    assign m_fall   = m_run && tick && sck_r;
    assign m_done   = m_fall && frame_full;
    assign m_shift  = m_fall && !frame_full;

    // Master frame state and SCK level.
    always_ff @(posedge clk) begin
        if (!rst_n || !cfg_en) begin
            m_run <= 1'b0;
            sck_r <= 1'b0;
        end else if (m_start) begin
            m_run <= 1'b1;
            sck_r <= 1'b0;
        end else if (m_run && tick) begin
            sck_r <= !sck_r;
            if (sck_r && frame_full)
                m_run <= 1'b0;
        end
    end

    assign sck_out = sck_r;

    // ---------------- slave side ----------------
    assign sel_eff_n = cfg_sw_sel ? cfg_sw_sel_val : sel_s;
    assign s_active  = cfg_en && !fcfg.master && !sel_eff_n;
    assign s_sample  = s_active && sck_s && !sck_prev;
    assign s_shift   = s_active && !sck_s && sck_prev;
    assign s_done    = cfg_en && !fcfg.master && frame_full;

    // Transmit holding byte; ignored while a master frame runs.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tx_buf <= '0;
        else if (tx_write && !m_run)
            tx_buf <= tx_data;
    end

    // ---------------- shared datapath ----------------
    assign eng_clear  = !cfg_en || m_done || s_done || (!fcfg.master && !s_active);
    assign eng_load   = m_start || (!fcfg.master && (bit_count == '0) && !s_sample);
    assign eng_sample = m_sample || s_sample;
    assign eng_shift  = m_shift || s_shift;
    assign eng_in     = fcfg.master ? ser_in : din_s;

    spi_frame_engine #(.FRAME_W(FRAME_W)) u_engine (
        .clk(clk), .rst_n(rst_n),
        .lsb_first(fcfg.lsb_first),
        .clear(eng_clear), .load(eng_load),
        .load_data(m_start ? tx_data : tx_buf),
        .sample(eng_sample), .shift(eng_shift), .in_bit(eng_in),
        .out_bit(out_bit), .rx_word(rx_word), .bit_count(bit_count)
    );

    // Receive register and ready flag; a new frame wins over a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data  <= '0;
            rx_ready <= 1'b0;
        end else if (m_done || s_done) begin
            rx_data  <= rx_word;
            rx_ready <= 1'b1;
        end else if (rx_read) begin
            rx_ready <= 1'b0;
        end
    end

    assign ser_out_en = cfg_en && !cfg_rx_only && (fcfg.master || s_active);
    assign ser_out    = ser_out_en && out_bit;

    AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !m_run |-> !sck_out) else $error("SCK high while idle"); // R1
    AST_READY_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ready) |-> $past(busy)) else $error("ready without frame"); // R2
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(fcfg)) else $error("settings moved mid-frame"); // R4
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> (!busy && !sck_out)) else $error("active while disabled"); // R9
endmodule

// File: tb/spi_port_tb_top.sv
// Bench: directed corners plus seeded random frames in both roles.
module spi_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_en = 0, cfg_master = 0, cfg_lsb_first = 0;
    logic [2:0] cfg_baud = 0;
    logic       cfg_sw_sel = 0, cfg_sw_sel_val = 1, cfg_rx_only = 0;
    logic [7:0] tx_data = 0;
    logic       tx_write = 0, rx_read = 0;
    logic [7:0] rx_data;
    logic       rx_ready, busy, sck_out, ser_out, ser_out_en;
    logic       sck_in = 0, sel_n_in = 1, ser_in = 0;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    spi_port dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_master(cfg_master),
        .cfg_baud(cfg_baud), .cfg_lsb_first(cfg_lsb_first), .cfg_sw_sel(cfg_sw_sel),
        .cfg_sw_sel_val(cfg_sw_sel_val), .cfg_rx_only(cfg_rx_only),
        .tx_data(tx_data), .tx_write(tx_write), .rx_read(rx_read),
        .rx_data(rx_data), .rx_ready(rx_ready), .busy(busy), .sck_out(sck_out),
        .sck_in(sck_in), .sel_n_in(sel_n_in), .ser_out(ser_out),
        .ser_out_en(ser_out_en), .ser_in(ser_in)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit bit_at(input logic [7:0] v, input int k, input bit lsb);
        return lsb ? v[k] : v[7-k];
    endfunction

    // Master frame with the bench acting as the far-end slave.
    task automatic master_frame(input logic [7:0] tx, input logic [7:0] rsp,
                                input int baud, input bit lsb, input bit rxo,
                                input bit mutate);
        logic [7:0] cap = '0;
        int  rises = 0, last = -1, cyc = 0;
        bit  per_ok = 1, oe_ok = 1, prev_sck;
        string tag = mutate ? "R4 R10" : (lsb ? "R3" : "R2");
        @(negedge clk);
        cfg_en = 1; cfg_master = 1; cfg_baud = 3'(baud); cfg_lsb_first = lsb;
        cfg_rx_only = rxo; cfg_sw_sel = 0; sel_n_in = 1; rx_read = 1;
        ser_in = bit_at(rsp, 0, lsb);
        @(negedge clk);
        rx_read = 0; tx_data = tx; tx_write = 1;
        @(negedge clk);
        tx_write = 0;
        check(busy == 1'b1, "R2 busy after write", busy, 1);
        prev_sck = sck_out;
        while (busy && cyc < 5000) begin
            cyc++;
            if (sck_out && !prev_sck) begin
                if (rises < 8) cap[lsb ? rises : 7 - rises] = ser_out;
                if (ser_out_en != !rxo) oe_ok = 0;
                if (last >= 0 && (cyc - last) != (2 << baud)) per_ok = 0;
                last = cyc;
                rises++;
                if (rises < 8) ser_in = bit_at(rsp, rises, lsb);
                if (mutate && rises == 1) begin
                    cfg_baud = ~3'(baud); cfg_lsb_first = !lsb; cfg_master = 0;
                    tx_data = ~tx; tx_write = 1;
                end
            end else begin
                tx_write = 0;
            end
            prev_sck = sck_out;
            @(negedge clk);
        end
        tx_write = 0;
        check(rises == 8, {tag, " eight SCK rises"}, rises, 8);
        check(per_ok, "R1 SCK period", per_ok, 1);
        check(sck_out == 1'b0, "R1 SCK idle low", sck_out, 0);
        check(rx_ready == 1'b1, {tag, " rx_ready at end"}, rx_ready, 1);
        check(rx_data == rsp, {tag, " rx_data"}, rx_data, rsp);
        if (!rxo) check(cap == tx, {tag, " bits sent"}, cap, tx);
        check(oe_ok, rxo ? "R8 output released" : "R11 master drives", oe_ok, 1);
        if (rxo) check(ser_out == 1'b0, "R8 ser_out low", ser_out, 0);
        cfg_master = 1; cfg_rx_only = 0;
    endtask

    // Slave frame of nbits, bench drives SCK with 8-clock phases.
    task automatic slave_frame(input logic [7:0] mosi, input logic [7:0] miso,
                               input bit lsb, input int nbits,
                               output logic [7:0] cap, output bit oe_seen);
        cap = '0; oe_seen = 0;
        @(negedge clk);
        cfg_en = 1; cfg_master = 0; cfg_lsb_first = lsb; cfg_rx_only = 0;
        rx_read = 1; tx_data = miso; tx_write = 1;
        @(negedge clk);
        rx_read = 0; tx_write = 0;
        repeat (6) @(negedge clk);
        for (int k = 0; k < nbits; k++) begin
            ser_in = bit_at(mosi, k, lsb);
            repeat (8) @(negedge clk);
            cap[lsb ? k : 7 - k] = ser_out;
            if (ser_out_en) oe_seen = 1;
            sck_in = 1;
            repeat (8) @(negedge clk);
            sck_in = 0;
        end
        repeat (8) @(negedge clk);
    endtask

    // Watchdog: ends a hung run as a failure.
    initial begin
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        n_fail++;
        n_chk++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] cap, a, b;
        bit oe;
        void'($urandom(32'h5A17));
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(busy == 0 && rx_ready == 0, "R9 reset idle", {busy, rx_ready}, 0);
        check(sck_out == 0 && ser_out_en == 0, "R9 reset pins", {sck_out, ser_out_en}, 0);

        // R9: write while disabled starts nothing.
        tx_data = 8'h3C; tx_write = 1; cfg_master = 1;
        @(negedge clk); tx_write = 0;
        check(busy == 0, "R9 write while disabled", busy, 0);

        // R1: every rate code.
        for (int c = 0; c < 8; c++) master_frame(8'hA5 ^ 8'(c), 8'h96 + 8'(c), c, 0, 0, 0);

        // R3: LSB first, R8: receive-only.
        master_frame(8'h01, 8'h80, 1, 1, 0, 0);
        master_frame(8'hC3, 8'h5E, 0, 0, 1, 0);

        // R10: read clears ready.
        @(negedge clk); rx_read = 1;
        @(negedge clk); rx_read = 0;
        check(rx_ready == 0, "R10 read clears ready", rx_ready, 0);

        // R4 R10: mid-frame config changes and write ignored.
        master_frame(8'h6D, 8'hB2, 2, 0, 0, 1);

        // R9: abandon a running frame.
        @(negedge clk); rx_read = 1; cfg_baud = 3; cfg_master = 1;
        @(negedge clk); rx_read = 0; tx_data = 8'hFF; tx_write = 1;
        @(negedge clk); tx_write = 0;
        repeat (40) @(negedge clk);
        cfg_en = 0;
        @(negedge clk);
        check(busy == 0 && sck_out == 0, "R9 disable stops frame", {busy, sck_out}, 0);
        repeat (300) @(negedge clk);
        check(rx_ready == 0, "R9 no ready after abort", rx_ready, 0);
        cfg_en = 1;

        // R11: slave deselected does not drive, selected does.
        @(negedge clk); cfg_master = 0; sel_n_in = 1;
        repeat (6) @(negedge clk);
        check(ser_out_en == 0, "R11 deselected slave quiet", ser_out_en, 0);
        sel_n_in = 0;
        repeat (6) @(negedge clk);
        check(ser_out_en == 1, "R11 selected slave drives", ser_out_en, 1);

        // R5: slave frames both orders.
        slave_frame(8'hB4, 8'h2D, 0, 8, cap, oe);
        check(rx_ready == 1 && rx_data == 8'hB4, "R5 slave rx msb", rx_data, 8'hB4);
        check(cap == 8'h2D, "R5 slave tx msb", cap, 8'h2D);
        slave_frame(8'h0E, 8'hE1, 1, 8, cap, oe);
        check(rx_data == 8'h0E && cap == 8'hE1, "R3 slave lsb first", {rx_data, cap}, 16'h0EE1);

        // R7: partial frame then deselect.
        slave_frame(8'hFF, 8'h00, 0, 3, cap, oe);
        sel_n_in = 1;
        repeat (6) @(negedge clk);
        check(busy == 0 && rx_ready == 0, "R7 partial dropped", {busy, rx_ready}, 0);
        sel_n_in = 0;
        slave_frame(8'h4B, 8'h99, 0, 8, cap, oe);
        check(rx_data == 8'h4B && cap == 8'h99, "R7 next frame whole", {rx_data, cap}, 16'h4B99);

        // R6: software select overrides the pin.
        sel_n_in = 1; cfg_sw_sel = 1; cfg_sw_sel_val = 0;
        slave_frame(8'h72, 8'h1F, 0, 8, cap, oe);
        check(rx_ready == 1 && rx_data == 8'h72, "R6 sw select active", rx_data, 8'h72);
        sel_n_in = 0; cfg_sw_sel_val = 1;
        slave_frame(8'h55, 8'hAA, 0, 8, cap, oe);
        check(rx_ready == 0 && !oe, "R6 pin ignored", {rx_ready, oe}, 0);
        cfg_sw_sel = 0; cfg_sw_sel_val = 1;
        slave_frame(8'h3A, 8'hC5, 1, 8, cap, oe);
        check(rx_data == 8'h3A && cap == 8'hC5, "R6 sw level ignored", {rx_data, cap}, 16'h3AC5);
        sel_n_in = 1;

        // Random master frames.
        for (int i = 0; i < 16; i++) begin
            a = 8'($urandom); b = 8'($urandom);
            master_frame(a, b, int'($urandom % 5), bit'($urandom % 2),
                         ($urandom % 4) == 0, 0);
        end

        // Random slave frames.
        sel_n_in = 0;
        for (int i = 0; i < 8; i++) begin
            bit l;
            a = 8'($urandom); b = 8'($urandom); l = bit'($urandom % 2);
            slave_frame(a, b, l, 8, cap, oe);
            check(rx_data == a && cap == b, "R5 random slave", {rx_data, cap}, {a, b});
        end
        sel_n_in = 1;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule